// File: doc/BRIEF.md
# RF Transmitter Mode and Clock-Output Controller

This block is the digital control core of a small UHF transmitter. It takes three control pins from a host (an amplitude-keying pin, a frequency-keying pin and an enable pin that may be left undriven) and decodes them into a power mode. The mode drives three enables: one for the crystal oscillator and PLL, one for the power amplifier, and one that closes the capacitor switch used for frequency keying. The analog parts themselves are not modelled. They appear only as these enables and as one "oscillator amplitude OK" input.

The block also produces a clock for the host: the crystal clock divided by eight. This output stays low until the oscillator amplitude indication has been synchronised into the crystal domain. It then starts at a rising boundary of the divided clock, so the host never sees a shortened first pulse. When the device powers down, the output drops at once. Every power-up restarts the divider from the same phase.

Top module: `uhf_tx_ctrl`

## Requirements
- R1: When `en_driven` is 0 (enable pin open), the effective enable is `ask_in | fsk_in`, and `en_level` has no effect on any output.
- R2: Power-down (`mode_o` = 0) occurs when both `ask_in` and `fsk_in` are 0 and the enable pin is open or driven low. In power-down `osc_pll_en`, `pa_en` and `fsk_sw_closed` are all 0.
- R3: Idle (`mode_o` = 1) occurs when the enable pin is driven low and `ask_in` or `fsk_in` is 1. In idle `osc_pll_en`, `pa_en` and `fsk_sw_closed` are all 0.
- R4: With the enable pin driven high and both keying pins at 0, `mode_o` = 2, `osc_pll_en` = 1, `pa_en` = 0 and `fsk_sw_closed` = 1.
- R5: In any powered-up mode, `osc_pll_en` = 1, `pa_en` equals `ask_in`, `fsk_sw_closed` equals the inverse of `fsk_in`, and `mode_o` is 3 when `ask_in` is 1 and 2 when it is 0.
- R6: `clk_out` is 0 whenever the block is not powered up, including throughout reset.
- R7: After power-up, `clk_out` stays 0 until `amp_ok` has passed a two-stage synchroniser. With `amp_ok` never asserted, `clk_out` stays 0.
- R8: `clk_out` opens only at a rising boundary of the divide-by-8 clock. Counting edges from the first edge at which the block is powered up, the gate opens at the first edge e with e mod 8 = 4 and e ≥ a + 3, where a is the edge after which `amp_ok` rose (a = 0 if it was high before edge 1). The output is then high on edges with e mod 8 in 4..7 and low otherwise, so the first high phase lasts a full 4 cycles.
- R9: Leaving the powered-up state forces `clk_out` to 0 in the same cycle, without waiting for a clock edge.
- R10: The divider restarts on every power-up, so a repeated power-up with the same `amp_ok` timing gives the same `clk_out` waveform.
- R11: Once the clock output has opened, it keeps running while the block stays powered up, even if `amp_ok` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ask_in | input | 1 | Amplitude-keying pin; 1 turns the amplifier on |
| fsk_in | input | 1 | Frequency-keying pin; 1 opens the capacitor switch |
| en_driven | input | 1 | 1 when the enable pin is actively driven, 0 when it is open |
| en_level | input | 1 | Level on the enable pin when it is driven |
| amp_ok | input | 1 | Oscillator amplitude indication (asynchronous) |
| mode_o | output | 2 | 0 power-down, 1 idle, 2 up with amplifier off, 3 up with amplifier on |
| osc_pll_en | output | 1 | Oscillator and PLL enable |
| pa_en | output | 1 | Power amplifier enable |
| fsk_sw_closed | output | 1 | 1 closes the capacitor switch (lower frequency) |
| clk_out | output | 1 | Host clock, crystal clock divided by 8, gated |

## Verification
The mode decoder is driven with all sixteen combinations of the two keying pins and the enable pin's driven flag and level. This separates the open-enable OR behaviour from driven-low idle and from driven-high power-up, and shows that the enable level has no effect while the pin is open. The clock gate is tried with `amp_ok` raised before power-up and at edges 2 and 5. The edge-2 case sits just past the boundary, so the output must wait a whole extra divided period. A run with `amp_ok` never raised shows the gate stays shut. Repeated power-ups, a power-down in the middle of a high phase, and a drop of `amp_ok` after the gate has opened show the phase restart, the immediate close, and the latched gate.

// File: rtl/uhf_tx_ctrl.sv
module uhf_tx_ctrl #(
  parameter int DIV         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ask_in,
  input  logic       fsk_in,
  input  logic       en_driven,
  input  logic       en_level,
  input  logic       amp_ok,
  output logic [1:0] mode_o,
  output logic       osc_pll_en,
  output logic       pa_en,
  output logic       fsk_sw_closed,
  output logic       clk_out
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] PRE_RISE = CW'(DIV / 2 - 1);

  logic any_req, eff_en, up;
  logic [SYNC_STAGES-1:0] amp_sync;
  logic [CW-1:0] div_cnt;
  logic clk_gate;

  assign any_req = ask_in | fsk_in;
  assign eff_en  = en_driven ? en_level : any_req;

  always_comb begin
    if (eff_en)       mode_o = ask_in ? 2'd3 : 2'd2;
    else if (any_req) mode_o = 2'd1;
    else              mode_o = 2'd0;
  end

  assign up            = mode_o[1];
  assign osc_pll_en    = up;
  assign pa_en         = up & ask_in;
  assign fsk_sw_closed = up & ~fsk_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   amp_sync <= '0;
    else if (!up) amp_sync <= '0;
    else          amp_sync <= {amp_sync[SYNC_STAGES-2:0], amp_ok};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   div_cnt <= '0;
    else if (!up) div_cnt <= '0;
    else          div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   clk_gate <= 1'b0;
    else if (!up) clk_gate <= 1'b0;
    else if (amp_sync[SYNC_STAGES-1] && div_cnt == PRE_RISE) clk_gate <= 1'b1;
  end

  assign clk_out = up & clk_gate & div_cnt[CW-1];
endmodule

// File: rtl/uhf_tx_ctrl_chk.sv
module uhf_tx_ctrl_chk #(
  parameter int DIV = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     en_driven,
  input logic                     en_level,
  input logic                     amp_ok,
  input logic                     osc_pll_en,
  input logic                     pa_en,
  input logic                     clk_out,
  input logic                     gate,
  input logic [$clog2(DIV)-1:0]   cnt
);
  localparam int CW = $clog2(DIV);

  a_r6_clk_low_down: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_pll_en |-> !clk_out);

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_driven && !en_level) |-> (!osc_pll_en && !pa_en));

  a_r7_wait_amp: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && !$past(amp_ok, 2)) |=> !gate);

  a_r8_open_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> cnt == CW'(DIV / 2));

  a_r8_no_runt: assert property (@(posedge clk) disable iff (!rst_n || !osc_pll_en)
    $rose(clk_out) |=> clk_out);

  a_r10_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_pll_en |=> cnt == '0);
endmodule

bind uhf_tx_ctrl uhf_tx_ctrl_chk #(.DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_driven(en_driven), .en_level(en_level),
  .amp_ok(amp_ok), .osc_pll_en(osc_pll_en), .pa_en(pa_en),
  .clk_out(clk_out), .gate(clk_gate), .cnt(div_cnt)
);

// File: tb/uhf_tx_ctrl_bench.sv
module uhf_tx_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic ask_in = 0, fsk_in = 0, en_driven = 0, en_level = 0, amp_ok = 0;
  logic [1:0] mode_o;
  logic osc_pll_en, pa_en, fsk_sw_closed, clk_out;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  uhf_tx_ctrl u_uhf_tx_ctrl (
    .clk(clk), .rst_n(rst_n), .ask_in(ask_in), .fsk_in(fsk_in),
    .en_driven(en_driven), .en_level(en_level), .amp_ok(amp_ok),
    .mode_o(mode_o), .osc_pll_en(osc_pll_en), .pa_en(pa_en),
    .fsk_sw_closed(fsk_sw_closed), .clk_out(clk_out)
  );

  // {ask, fsk, en_driven, en_level, mode[1:0], osc, pa, sw_closed}
  localparam logic [8:0] VEC [16] = '{
    9'b0000_00_000, 9'b0001_00_000, 9'b0010_00_000, 9'b0011_10_101,
    9'b0100_10_100, 9'b0101_10_100, 9'b0110_01_000, 9'b0111_10_100,
    9'b1000_11_111, 9'b1001_11_111, 9'b1010_01_000, 9'b1011_11_111,
    9'b1100_11_110, 9'b1101_11_110, 9'b1110_01_000, 9'b1111_11_110
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic pins(input logic a, input logic f, input logic d, input logic l);
    ask_in = a; fsk_in = f; en_driven = d; en_level = l;
  endtask

  task automatic power_down(input int n);
    @(negedge clk);
    pins(0, 0, 0, 0); amp_ok = 0;
    repeat (n) @(negedge clk);
  endtask

  // Power up (open enable, FSK high). amp_at = 0: amp_ok raised with power-up,
  // otherwise raised after that edge; a large value means never raised.
  task automatic clk_run(input int amp_at, input string open_tag);
    int first = 4;
    while (first < amp_at + 3) first += 8;
    @(negedge clk);
    pins(0, 1, 0, 0);
    amp_ok = (amp_at == 0);
    for (int k = 1; k <= 24; k++) begin
      @(negedge clk);
      if (k == amp_at) amp_ok = 1;
      if (k < first) chk("R7 clk_out before open", clk_out, 0);
      else chk(open_tag, clk_out, (k % 8) >= 4);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // reset: pins request power-up and amp_ok high, clk_out must stay low (R6)
    pins(0, 1, 0, 0); amp_ok = 1;
    repeat (6) @(negedge clk);
    chk("R6 clk_out in reset", clk_out, 0);
    pins(0, 0, 0, 0); amp_ok = 0;
    #1 chk("R2 mode after reset", mode_o, 0);
    @(negedge clk); rst_n = 1;

    // mode decode table, amp_ok low throughout
    for (int i = 0; i < 16; i++) begin
      logic [8:0] v = VEC[i];
      string tag;
      @(negedge clk);
      pins(v[8], v[7], v[6], v[5]);
      #1;
      if (v[4:3] == 2'd0) tag = "R2";
      else if (v[4:3] == 2'd1) tag = "R3";
      else if (v[6] && v[5] && !v[8] && !v[7]) tag = "R4";
      else if (!v[6]) tag = "R1";
      else tag = "R5";
      chk(tag, {mode_o, osc_pll_en, pa_en, fsk_sw_closed}, v[4:0]);
      @(negedge clk);
      chk("R7 clk_out without amp_ok", clk_out, 0);
    end

    power_down(3);
    clk_run(0, "R8 open at edge 4");
    power_down(3);
    clk_run(5, "R8 open at edge 12");
    power_down(3);
    clk_run(2, "R8 just past boundary");
    power_down(3);
    clk_run(99, "R7 never opens");
    power_down(3);
    clk_run(0, "R10 same phase on repeat");

    // R9: power down in the middle of a high phase
    power_down(3);
    @(negedge clk); pins(0, 1, 0, 0); amp_ok = 1;
    repeat (5) @(negedge clk);
    chk("R9 high before power-down", clk_out, 1);
    pins(0, 0, 0, 0);
    #1 chk("R9 clk_out drops at once", clk_out, 0);
    chk("R2 osc off after drop", osc_pll_en, 0);

    // R11: amp_ok falls after the gate opened; driven-high enable with ASK keying
    power_down(3);
    @(negedge clk); pins(1, 0, 1, 1); amp_ok = 1;
    for (int k = 1; k <= 24; k++) begin
      @(negedge clk);
      if (k == 6) amp_ok = 0;
      if (k == 9) ask_in = 0;
      if (k >= 4) chk("R11 keeps running", clk_out, (k % 8) >= 4);
    end
    chk("R5 pa follows ask", pa_en, 0);
    power_down(2);
    chk("R6 clk_out low when down", clk_out, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule